// File: doc/BRIEF.md
# Five-Input Configurable Logic Cell

This block is a programmable logic cell. It can realise any Boolean function of five inputs. It splits the function on one input, the split variable `a`, into two cofactors over the remaining four inputs `b`, `c`, `d` and `e`:

- The cofactor for `a=1` is held in a 16-entry lookup table, the G table.
- The cofactor for `a=0` is held in a second 16-entry table, the F table.
- A fully programmable 8-entry mixing table, the H table, is addressed by `a` and the two cofactor outputs, and produces the cell result.

A configuration bit chooses how that result reaches `cell_out`. It either goes straight to the output or through a flip-flop. The flip-flop form suits sequential circuits.

All table contents and the mode bit sit in one 41-bit shift chain. The chain is filled one bit per clock while `cfg_en` is high. To map a function onto the cell:

1. Take its 32-entry truth table.
2. Split the entries by the value of `a` to get the two cofactor tables.
3. Load the mixer with the selection pattern 0xD8.
4. Shift the whole image in.

The two cofactor outputs are also available on ports of their own.

Top module: `logic_cell_5in`

## Requirements
- R1: A synchronous active-high `rst` clears the configuration chain and the output flip-flop. After the reset edge, `cell_out`, `g_out` and `f_out` are all 0 for every input value.
- R2: While `cfg_en` is low, `cfg_din` has no effect and the configuration chain keeps its contents.
- R3: On each clock edge with `cfg_en` high, the chain takes `cfg_din` as its newest bit. After 41 such edges, the bits sent first to last are in this order:
  - H entries 0 to 7,
  - G entries 0 to 15,
  - F entries 0 to 15,
  - the mode bit.
- R4: `g_out` equals G entry `{e,d,c,b}` and `f_out` equals F entry `{e,d,c,b}`, with `b` as the least significant address bit. Both are combinational.
- R5: The mixer output is H entry `a + 2*g_out + 4*f_out`. Any 8-bit pattern may be loaded into H, so the mixer is not limited to a multiplexer.
- R6: With the mode bit at 1, `cell_out` equals the mixer output in the same cycle, with no register on the path.
- R7: With the mode bit at 0, `cell_out` is the mixer output sampled at the previous rising clock edge.
- R8: With H = 0xD8, G entry k = T[2k+1] and F entry k = T[2k], `cell_out` realises the truth table T, indexed by `x_in` = `{e,d,c,b,a}`.
- R9: When `rst` and `cfg_en` are both high in the same cycle, the reset wins and no bit is shifted in.
- R10: In registered mode, a clock edge that both shifts the chain and captures the output stores the mixer value formed from the configuration that held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables one configuration shift per clock |
| cfg_din | input | 1 | Serial configuration data |
| x_in | input | 5 | Logic inputs `{e,d,c,b,a}`; bit 0 is the split variable `a` |
| cell_out | output | 1 | Cell result, registered or combinational |
| g_out | output | 1 | Output of the cofactor table for `a=1` |
| f_out | output | 1 | Output of the cofactor table for `a=0` |

## Verification
Two pairs of actions can fall on the same edge.

The first pair is a configuration shift and the output flip-flop capture. The bench loads a function in registered mode, applies an input and raises `cfg_en` for exactly that edge. It then expects `cell_out` to hold the value from the old truth table, not from the partly shifted chain.

The second pair is reset and shift. The bench asserts both together, after an all-ones image in combinational mode, and judges the result by the all-zero outputs.

The rest of the bench sweeps all 32 input values for several random truth tables in both modes, plus a random non-multiplexer mixer pattern.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
    // default address width of each cofactor table
    localparam int unsigned COF_IN_DEF = 4;
    // mixer inputs: split variable, G output, F output
    localparam int unsigned MIX_IN     = 3;
    localparam int unsigned MIX_BITS   = 1 << MIX_IN;
    // mixer image that turns H into a plain 2:1 select on the split variable
    localparam logic [MIX_BITS-1:0] MIX_SELECT = 8'hD8;
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
    parameter int unsigned LEN = 41
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           shift_in,
    output logic [LEN-1:0] bits
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else if (shift_en) begin
            st_d.bits = {shift_in, st_q.bits[LEN-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits = st_q.bits;

    // R2: contents hold when shifting is off
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(bits));

    // R3: newest bit enters at the top
    a_r3_entry: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> bits[LEN-1] == $past(shift_in));

    // R3: older bits move one place toward index 0
    a_r3_move: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> bits[LEN-2:0] == $past(bits[LEN-1:1]));
endmodule

// File: rtl/lcell_lut.sv
module lcell_lut #(
    parameter int unsigned N = 4
) (
    input  logic [(1<<N)-1:0] table_bits,
    input  logic [N-1:0]      addr,
    output logic              y
);
    always_comb begin
        y = table_bits[addr];
    end
endmodule

// File: rtl/lcell_out_stage.sv
module lcell_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic comb_sel,
    input  logic d,
    output logic y
);
    typedef struct packed {
        logic held;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d.held = d;
        if (rst) begin
            st_d.held = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign y = comb_sel ? d : st_q.held;

    // R6: bypass mode gives the live value
    a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
        comb_sel |-> y == d);

    // R7: registered mode shows last edge's value
    a_r7_registered: assert property (@(posedge clk) disable iff (rst)
        (!comb_sel && !$past(rst)) |-> y == $past(d));
endmodule

// File: rtl/logic_cell_5in.sv
module logic_cell_5in #(
    parameter int unsigned LUT_IN = lcell_pkg::COF_IN_DEF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_en,
    input  logic            cfg_din,
    input  logic [LUT_IN:0] x_in,
    output logic            cell_out,
    output logic            g_out,
    output logic            f_out
);
    localparam int unsigned LUT_BITS  = 1 << LUT_IN;
    localparam int unsigned MIX_BITS  = lcell_pkg::MIX_BITS;
    localparam int unsigned CHAIN_LEN = 2 * LUT_BITS + MIX_BITS + 1;
    localparam int unsigned SEL_POS   = CHAIN_LEN - 1;

    logic [CHAIN_LEN-1:0] chain;
    logic [1:0]           cof_y;
    logic                 mix_y;

    lcell_cfg_chain #(.LEN(CHAIN_LEN)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .shift_in (cfg_din),
        .bits     (chain)
    );

    // k=1: cofactor for a=1 (G), k=0: cofactor for a=0 (F)
    for (genvar k = 0; k < 2; k++) begin : g_cof
        localparam int unsigned BASE = MIX_BITS + (1 - k) * LUT_BITS;
        lcell_lut #(.N(LUT_IN)) u_lut (
            .table_bits (chain[BASE +: LUT_BITS]),
            .addr       (x_in[LUT_IN:1]),
            .y          (cof_y[k])
        );
    end

    assign g_out = cof_y[1];
    assign f_out = cof_y[0];

    lcell_lut #(.N(lcell_pkg::MIX_IN)) u_mix (
        .table_bits (chain[MIX_BITS-1:0]),
        .addr       ({f_out, g_out, x_in[0]}),
        .y          (mix_y)
    );

    lcell_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .comb_sel (chain[SEL_POS]),
        .d        (mix_y),
        .y        (cell_out)
    );

    // R8: with the select image loaded, the mixer picks G or F by a
    a_r8_shannon: assert property (@(posedge clk) disable iff (rst)
        (chain[MIX_BITS-1:0] == lcell_pkg::MIX_SELECT && chain[SEL_POS])
        |-> cell_out == (x_in[0] ? g_out : f_out));
endmodule

// File: tb/tb_logic_cell_5in.sv
`timescale 1ns/1ps
module tb_logic_cell_5in;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [4:0] x_in = '0;
    logic       cell_out, g_out, f_out;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    logic_cell_5in dut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .x_in(x_in), .cell_out(cell_out), .g_out(g_out), .f_out(f_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic send(input logic b);
        @(negedge clk);
        cfg_en  = 1'b1;
        cfg_din = b;
    endtask

    // R3 order: H[0..7], G[0..15], F[0..15], mode bit
    task automatic load(input logic [7:0] h, input logic [15:0] g,
                        input logic [15:0] f, input logic byp);
        for (int i = 0; i < 8; i++)  send(h[i]);
        for (int i = 0; i < 16; i++) send(g[i]);
        for (int i = 0; i < 16; i++) send(f[i]);
        send(byp);
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    function automatic logic [15:0] cof(input logic [31:0] tt, input int a);
        logic [15:0] r;
        for (int k = 0; k < 16; k++) r[k] = tt[2*k + a];
        return r;
    endfunction

    task automatic sweep(input logic [31:0] tt, input logic byp);
        load(8'hD8, cof(tt, 1), cof(tt, 0), byp);
        for (int x = 0; x < 32; x++) begin
            @(negedge clk);
            x_in = x[4:0];
            if (byp) begin
                #2;
                check("R6/R8 comb", cell_out, tt[x]);
            end else begin
                @(posedge clk);
                #2;
                check("R7/R8 reg", cell_out, tt[x]);
            end
            check("R4 g_out", g_out, tt[{x[4:1], 1'b1}]);
            check("R4 f_out", f_out, tt[{x[4:1], 1'b0}]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] tt;
        logic [7:0]  h;
        logic [15:0] g, f;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int x = 0; x < 32; x += 7) begin
            @(negedge clk);
            x_in = x[4:0];
            #2;
            check("R1 cell_out", cell_out, 1'b0);
            check("R1 g_out", g_out, 1'b0);
            check("R1 f_out", f_out, 1'b0);
        end

        // R8 fixed patterns and random tables, both modes
        sweep(32'hAAAA_AAAA, 1'b1);  // f = a
        sweep(32'h9669_6996, 1'b0);  // 5-input parity
        for (int n = 0; n < 6; n++) begin
            tt = $urandom;
            sweep(tt, n[0]);
            sweep(tt, ~n[0]);
        end

        // R5: random mixer pattern, combinational mode
        for (int n = 0; n < 3; n++) begin
            h = $urandom; g = $urandom; f = $urandom;
            load(h, g, f, 1'b1);
            for (int x = 0; x < 32; x++) begin
                @(negedge clk);
                x_in = x[4:0];
                #2;
                check("R5 mixer", cell_out,
                      h[{f[x[4:1]], g[x[4:1]], x[0]}]);
            end
        end

        // R2: cfg_din toggles with cfg_en low, then verify unchanged
        tt = 32'h1234_ABCD;
        load(8'hD8, cof(tt, 1), cof(tt, 0), 1'b1);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            cfg_din = i[0];
        end
        for (int x = 0; x < 32; x++) begin
            @(negedge clk);
            x_in = x[4:0];
            #2;
            check("R2 hold", cell_out, tt[x]);
        end

        // R10: shift and capture on the same edge in registered mode
        tt = 32'hF0C3_5A96;
        for (int x = 0; x < 32; x += 5) begin
            load(8'hD8, cof(tt, 1), cof(tt, 0), 1'b0);
            @(negedge clk);
            x_in = x[4:0];
            cfg_en = 1'b1;
            cfg_din = 1'b0;
            @(posedge clk);
            #2;
            check("R10 capture", cell_out, tt[x]);
            @(negedge clk);
            cfg_en = 1'b0;
        end

        // R9: reset and shift together, after an all-ones comb image
        load(8'hFF, 16'hFFFF, 16'hFFFF, 1'b1);
        @(negedge clk);
        #2;
        check("R9 preload", cell_out, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        cfg_en = 1'b1;
        cfg_din = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cfg_en = 1'b0;
        for (int x = 0; x < 32; x += 3) begin
            @(negedge clk);
            x_in = x[4:0];
            #2;
            check("R9 cell_out", cell_out, 1'b0);
            check("R9 g_out", g_out, 1'b0);
            check("R9 f_out", f_out, 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule